// File: doc/BRIEF.md
# Time-Bucket Stream Packer with Overflow Control

The block sits in a front-end readout path between the hit source and the output link. A free-running bucket timer cuts time into fixed intervals of `BUCKET_CYC` clock cycles. The default of 12500 cycles gives 100 us at 125 MHz. Hits that arrive during an interval are written to a buffer without being committed. When the interval closes, the block either commits them and queues a marker word that carries the bucket's timestamp, or discards the whole bucket. Because every bucket yields a marker, even an empty one, downstream logic can tell a quiet interval apart from a lost one.

Two overflow mechanisms can each be enabled on their own. With automatic drop enabled, a bucket whose hits do not fit in the buffer is discarded as a unit, and a flagged marker takes its place. With the pause mechanism enabled, the block raises `busy` as a pause request when buffer occupancy climbs past a high-water mark, and it holds its output whenever the fast-control pause level is asserted. A saturating counter records every bucket that was lost in full. The time-zero command restarts the timestamp.

Top module: `tbucket_stream_mgr`

## Requirements
- R1: Hit words leave in arrival order with `out_marker`=0. Each closed bucket that is not lost to R6 yields exactly one marker word with `out_marker`=1, placed after that bucket's hits. The marker fields are: timestamp in bits [15:0], hit count in [23:16], empty flag in bit 24, drop flag in bit 25, and zeros above. The timestamp counts buckets since time zero and rises by one per bucket.
- R2: A bucket spans `BUCKET_CYC` cycles. A hit sampled in the last cycle of a bucket belongs to that bucket.
- R3: A bucket with no hits yields a marker with empty=1, drop=0 and count 0.
- R4: With `cfg_drop_en`=1, a hit that arrives while the buffer holds `DEPTH` words marks the bucket as overflowed. At close, none of that bucket's hits are sent, the marker has drop=1, empty=0 and count 0, and `drop_count` increments.
- R5: With `cfg_drop_en`=0, an overflowed bucket keeps the hits already stored and loses only the excess. Its marker has drop=1 and count equal to the number of hits kept, and `drop_count` is unchanged.
- R6: If the marker queue is full when a bucket closes, that bucket is discarded with no marker, which leaves a gap in the timestamp sequence. `drop_count` increments.
- R7: `drop_count` saturates at its all-ones value.
- R8: With `cfg_pause_en`=1, `busy` rises one cycle after occupancy (committed plus in-progress words) reaches `cfg_busy_hi` or above. It stays high until occupancy falls to `cfg_busy_lo` or below.
- R9: With `cfg_pause_en`=1 and `fc_pause`=1, `out_valid` is 0. Output resumes once `fc_pause` drops.
- R10: With `cfg_pause_en`=0, `fc_pause` has no effect on the output and `busy` stays 0.
- R11: `fc_time_zero` discards the hits of the bucket in progress without a marker and restarts both the bucket timer and the timestamp at 0.
- R12: During and after reset, `out_valid`, `busy` and `drop_count` are 0.
- R13: While `out_valid`=1 and `out_ready`=0, the presented word is neither lost nor repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_drop_en | input | 1 | Enable whole-bucket drop on overflow |
| cfg_pause_en | input | 1 | Enable pause input and busy request |
| cfg_busy_hi | input | $clog2(DEPTH)+1 | Occupancy at which busy rises |
| cfg_busy_lo | input | $clog2(DEPTH)+1 | Occupancy at which busy falls |
| fc_pause | input | 1 | Fast-control pause level |
| fc_time_zero | input | 1 | Fast-control time-zero pulse |
| hit_valid | input | 1 | Hit present this cycle |
| hit_data | input | DATA_W | Hit word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Link accepts the word |
| out_marker | output | 1 | Word is a bucket marker |
| out_data | output | DATA_W | Hit or marker word |
| busy | output | 1 | Pause request to upstream |
| drop_count | output | DROP_W | Saturating count of lost buckets |

## Verification
A hit sampled in bucket k can appear at the output no earlier than the cycle after bucket k closes. Its marker follows once the hits ahead of it have drained, and `busy` and `drop_count` settle on the edge right after the event that moves them. The bench therefore drives stimulus one bucket at a time, lined up with a time-zero pulse, and queues the expected words as each bucket starts. A monitor compares every accepted word on the falling edge. Level checks on `busy`, `drop_count` and `out_valid` are made only at bucket ends, where every register on the path has settled.

// File: rtl/tbucket_pkg.sv
package tbucket_pkg;
  localparam int TS_W   = 16;
  localparam int CNT_FW = 8;
  localparam int MARK_W = TS_W + CNT_FW + 2;

  typedef struct packed {
    logic              drop;
    logic              empty;
    logic [CNT_FW-1:0] count;
    logic [TS_W-1:0]   ts;
  } marker_t;
endpackage

// File: rtl/tbucket_hit_buffer.sv
module tbucket_hit_buffer #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              commit,
  input  logic              rollback,
  input  logic              pop,
  output logic [DATA_W-1:0] rd_data,
  output logic [AW:0]       fill,
  output logic              full
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW:0] wr_q, wr_d, cm_q, cm_d, rd_q, rd_d;

  always_comb begin
    wr_d = rollback ? cm_q : wr_q + {{AW{1'b0}}, push};
    cm_d = commit ? wr_d : cm_q;
    rd_d = rd_q + {{AW{1'b0}}, pop};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      cm_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      cm_q <= cm_d;
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q[AW-1:0]] <= push_data;
  end

  assign rd_data = mem[rd_q[AW-1:0]];
  assign fill    = wr_q - rd_q;
  assign full    = (fill == (AW+1)'(DEPTH));

  // R1
  pop_committed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (rd_q != cm_q));
  // R4
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= (AW+1)'(DEPTH));
endmodule

// File: rtl/tbucket_marker_fifo.sv
module tbucket_marker_fifo #(
  parameter int W     = 26,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]   cnt_q, cnt_d;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = push ? inc(wp_q) : wp_q;
    rp_d  = pop  ? inc(rp_q) : rp_q;
    cnt_d = cnt_q + {{AW{1'b0}}, push} - {{AW{1'b0}}, pop};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign full  = (cnt_q == (AW+1)'(DEPTH));
  assign empty = (cnt_q == '0);

  // R1
  mq_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R6
  mq_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
endmodule

// File: rtl/tbucket_busy_hyst.sv
module tbucket_busy_hyst #(
  parameter int FW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [FW-1:0] fill,
  input  logic [FW-1:0] hi,
  input  logic [FW-1:0] lo,
  output logic          busy
);
  logic busy_q, busy_d;

  always_comb begin
    busy_d = busy_q;
    if (!en)             busy_d = 1'b0;
    else if (fill >= hi) busy_d = 1'b1;
    else if (fill <= lo) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  assign busy = busy_q;

  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> ($past(fill) >= $past(hi)));
  // R8
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (!$past(en) || ($past(fill) <= $past(lo))));
  // R10
  busy_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> !busy_q);
endmodule

// File: rtl/tbucket_stream_mgr.sv
module tbucket_stream_mgr
  import tbucket_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int DEPTH      = 16,
  parameter int MQ_DEPTH   = 4,
  parameter int BUCKET_CYC = 12500,
  parameter int DROP_W     = 16,
  localparam int AW        = $clog2(DEPTH),
  localparam int TW        = $clog2(BUCKET_CYC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_drop_en,
  input  logic              cfg_pause_en,
  input  logic [AW:0]       cfg_busy_hi,
  input  logic [AW:0]       cfg_busy_lo,
  input  logic              fc_pause,
  input  logic              fc_time_zero,
  input  logic              hit_valid,
  input  logic [DATA_W-1:0] hit_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_marker,
  output logic [DATA_W-1:0] out_data,
  output logic              busy,
  output logic [DROP_W-1:0] drop_count
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic [TW-1:0]     tick_q, tick_d;
  logic [TS_W-1:0]   ts_q, ts_d;
  logic [CNT_FW-1:0] bcnt_q, bcnt_d, cnt_eff, sent_q, sent_d;
  logic              bovf_q, bovf_d, ovf_eff;
  logic [DROP_W-1:0] drop_q, drop_d;
  logic              close, hit_ok, drop_inc, commit, rollback;
  logic              buf_full, buf_pop, mq_push, mq_pop, mq_full, mq_empty;
  logic [AW:0]       buf_fill;
  logic [DATA_W-1:0] buf_rd;
  logic [MARK_W-1:0] mq_dout;
  marker_t           mk, head;
  logic              paused, hit_phase, fire;

  assign close   = (tick_q == TW'(BUCKET_CYC-1));
  assign hit_ok  = hit_valid & ~buf_full;
  assign ovf_eff = bovf_q | (hit_valid & buf_full);
  assign cnt_eff = bcnt_q + {{(CNT_FW-1){1'b0}}, hit_ok};

  always_comb begin
    tick_d   = close ? '0 : tick_q + 1'b1;
    ts_d     = ts_q;
    bcnt_d   = cnt_eff;
    bovf_d   = ovf_eff;
    commit   = 1'b0;
    rollback = 1'b0;
    mq_push  = 1'b0;
    drop_inc = 1'b0;
    mk       = '0;
    if (fc_time_zero) begin
      tick_d   = '0;
      ts_d     = '0;
      bcnt_d   = '0;
      bovf_d   = 1'b0;
      rollback = 1'b1;
    end else if (close) begin
      ts_d   = ts_q + 1'b1;
      bcnt_d = '0;
      bovf_d = 1'b0;
      mk.ts  = ts_q;
      if (mq_full) begin
        rollback = 1'b1;
        drop_inc = 1'b1;
      end else if (ovf_eff && cfg_drop_en) begin
        rollback = 1'b1;
        drop_inc = 1'b1;
        mq_push  = 1'b1;
        mk.drop  = 1'b1;
      end else begin
        commit   = 1'b1;
        mq_push  = 1'b1;
        mk.drop  = ovf_eff;
        mk.empty = (cnt_eff == '0);
        mk.count = cnt_eff;
      end
    end
    drop_d = (drop_inc && (drop_q != '1)) ? drop_q + 1'b1 : drop_q;
  end

  // output sequencer: head marker's hits first, then the marker itself
  assign head       = marker_t'(mq_dout);
  assign paused     = cfg_pause_en & fc_pause;
  assign hit_phase  = (sent_q != head.count);
  assign out_valid  = ~mq_empty & ~paused;
  assign out_marker = ~hit_phase;
  assign out_data   = hit_phase ? buf_rd : {{(DATA_W-MARK_W){1'b0}}, mq_dout};
  assign fire       = out_valid & out_ready;
  assign buf_pop    = fire & hit_phase;
  assign mq_pop     = fire & ~hit_phase;
  assign sent_d     = mq_pop ? '0 : sent_q + {{(CNT_FW-1){1'b0}}, buf_pop};

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      tick_q <= '0;
      ts_q   <= '0;
      bcnt_q <= '0;
      bovf_q <= 1'b0;
      drop_q <= '0;
      sent_q <= '0;
    end else begin
      tick_q <= tick_d;
      ts_q   <= ts_d;
      bcnt_q <= bcnt_d;
      bovf_q <= bovf_d;
      drop_q <= drop_d;
      sent_q <= sent_d;
    end
  end

  assign drop_count = drop_q;

  tbucket_hit_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_i), .push(hit_ok), .push_data(hit_data),
    .commit(commit), .rollback(rollback), .pop(buf_pop),
    .rd_data(buf_rd), .fill(buf_fill), .full(buf_full));

  tbucket_marker_fifo #(.W(MARK_W), .DEPTH(MQ_DEPTH)) u_mq (
    .clk(clk), .rst_n(rst_i), .push(mq_push), .din(mk), .pop(mq_pop),
    .dout(mq_dout), .full(mq_full), .empty(mq_empty));

  tbucket_busy_hyst #(.FW(AW+1)) u_busy (
    .clk(clk), .rst_n(rst_i), .en(cfg_pause_en), .fill(buf_fill),
    .hi(cfg_busy_hi), .lo(cfg_busy_lo), .busy(busy));

  // R7
  drop_step_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (drop_q != $past(drop_q)) |-> (drop_q == $past(drop_q) + 1'b1));
  // R13
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (out_valid && !out_ready) |=> ($stable(sent_q) || !out_valid));
  // R11
  tz_restart_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $past(fc_time_zero) |-> (ts_q == '0 && bcnt_q == '0));
endmodule

// File: tb/tbucket_stream_mgr_bench.sv
module tbucket_stream_mgr_bench;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 8;
  localparam int MQD    = 4;
  localparam int BCYC   = 16;
  localparam int DROP_W = 2;
  localparam int AW     = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n, cfg_drop_en, cfg_pause_en, fc_pause, fc_time_zero;
  logic [AW:0] cfg_busy_hi, cfg_busy_lo;
  logic hit_valid, out_valid, out_ready, out_marker, busy;
  logic [DATA_W-1:0] hit_data, out_data;
  logic [DROP_W-1:0] drop_count;

  int n_chk = 0, n_err = 0;
  int exp_ts = 0;
  int hit_id = 0;
  bit done = 0;
  logic [DATA_W:0] exp_q [$];
  string tag_q [$];

  always #(CLK_P/2) clk = ~clk;

  tbucket_stream_mgr #(.DATA_W(DATA_W), .DEPTH(DEPTH), .MQ_DEPTH(MQD),
    .BUCKET_CYC(BCYC), .DROP_W(DROP_W)) u_tbucket_stream_mgr (
    .clk(clk), .rst_n(rst_n), .cfg_drop_en(cfg_drop_en), .cfg_pause_en(cfg_pause_en),
    .cfg_busy_hi(cfg_busy_hi), .cfg_busy_lo(cfg_busy_lo), .fc_pause(fc_pause),
    .fc_time_zero(fc_time_zero), .hit_valid(hit_valid), .hit_data(hit_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_marker(out_marker),
    .out_data(out_data), .busy(busy), .drop_count(drop_count));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W:0] mk(input int ts, input int cnt, input bit e, input bit d);
    return {1'b1, 6'b0, d, e, cnt[7:0], ts[15:0]};
  endfunction

  // monitor: compare every accepted word against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R1 actual=%0h expected=none", {out_marker, out_data});
      end else begin
        check(tag_q.pop_front(), {out_marker, out_data}, exp_q.pop_front());
      end
    end
  end

  // one bucket: hits in cycles [s, s+n), ready per rmask bit
  task automatic bucket(input int s, input int n, input logic [15:0] rmask,
                        input bit lost, input string tag);
    int acc = (n > DEPTH) ? DEPTH : n;
    bit ovf = (n > DEPTH);
    int base = hit_id;
    if (!lost) begin
      if (!(ovf && cfg_drop_en)) begin
        for (int i = 0; i < acc; i++) begin
          exp_q.push_back({1'b0, 32'hA000_0000 + 32'(base + i)});
          tag_q.push_back(tag);
        end
        exp_q.push_back(mk(exp_ts, acc, acc == 0, ovf));
      end else begin
        exp_q.push_back(mk(exp_ts, 0, 1'b0, 1'b1));
      end
      tag_q.push_back(tag);
    end
    exp_ts++;
    for (int c = 0; c < BCYC; c++) begin
      hit_valid = (c >= s) && (c < s + n);
      hit_data  = 32'hA000_0000 + 32'(hit_id);
      if (hit_valid) hit_id++;
      out_ready = rmask[c];
      @(posedge clk); #1;
    end
    hit_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cfg_drop_en = 1'b1; cfg_pause_en = 1'b0; fc_pause = 1'b0;
    fc_time_zero = 1'b0; hit_valid = 1'b0; hit_data = '0; out_ready = 1'b1;
    cfg_busy_hi = 4'd6; cfg_busy_lo = 4'd2;
    repeat (3) @(posedge clk);
    #1;
    check("R12 valid in reset", 64'(out_valid), 64'd0);
    check("R12 busy in reset", 64'(busy), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R12 drop after reset", 64'(drop_count), 64'd0);
    check("R12 valid after reset", 64'(out_valid), 64'd0);
    fc_time_zero = 1'b1; @(posedge clk); #1; fc_time_zero = 1'b0;

    bucket(0, 3, 16'hFFFF, 0, "R1 hits+marker");
    bucket(0, 0, 16'hFFFF, 0, "R3 empty marker");
    bucket(0, 9, 16'hFFFF, 0, "R4 auto drop");
    check("R4 drop count", 64'(drop_count), 64'd1);
    cfg_drop_en = 1'b0;
    bucket(0, 10, 16'hFFFF, 0, "R5 keep stored");
    check("R5 drop count unchanged", 64'(drop_count), 64'd1);
    cfg_drop_en = 1'b1;
    bucket(0, 0, 16'hFFFF, 0, "R3 empty after drain");
    bucket(15, 1, 16'hFFFF, 0, "R2 last-cycle hit");

    cfg_pause_en = 1'b1;
    bucket(0, 0, 16'hFFFF, 0, "R13 drain");
    bucket(0, 7, 16'h0000, 0, "R13 stalled words");
    check("R8 busy at high mark", 64'(busy), 64'd1);
    bucket(0, 0, 16'h000F, 0, "R13 partial drain");
    check("R8 busy held above low mark", 64'(busy), 64'd1);
    bucket(0, 0, 16'h0003, 0, "R13 partial drain");
    check("R8 busy released at low mark", 64'(busy), 64'd0);
    bucket(0, 0, 16'hFFFF, 0, "R13 full drain");

    bucket(0, 2, 16'hFFFF, 0, "R9 pre-pause");
    fc_pause = 1'b1;
    bucket(0, 0, 16'hFFFF, 0, "R9 paused bucket");
    check("R9 output held by pause", 64'(out_valid), 64'd0);
    fc_pause = 1'b0;
    bucket(0, 0, 16'hFFFF, 0, "R9 resumed");

    cfg_pause_en = 1'b0; fc_pause = 1'b1;
    bucket(0, 7, 16'h0000, 0, "R10 pause ignored");
    check("R10 busy stays low", 64'(busy), 64'd0);
    bucket(0, 0, 16'hFFFF, 0, "R10 pause ignored");
    fc_pause = 1'b0;

    bucket(0, 0, 16'h0000, 0, "R6 queued");
    bucket(0, 0, 16'h0000, 0, "R6 queued");
    bucket(0, 0, 16'h0000, 0, "R6 queued");
    bucket(0, 0, 16'h0000, 1, "R6 lost");
    check("R6 drop count", 64'(drop_count), 64'd2);
    bucket(0, 0, 16'hFFFF, 0, "R6 after gap");

    bucket(0, 9, 16'hFFFF, 0, "R7 drop");
    check("R7 drop count", 64'(drop_count), 64'd3);
    bucket(0, 0, 16'hFFFF, 0, "R7 gap");
    bucket(0, 9, 16'hFFFF, 0, "R7 drop");
    check("R7 drop count saturated", 64'(drop_count), 64'd3);

    for (int c = 0; c < 5; c++) begin
      hit_valid = (c < 3);
      hit_data  = 32'hA000_0000 + 32'(hit_id);
      if (hit_valid) hit_id++;
      @(posedge clk); #1;
    end
    hit_valid = 1'b0;
    fc_time_zero = 1'b1; @(posedge clk); #1; fc_time_zero = 1'b0;
    exp_ts = 0;
    bucket(0, 1, 16'hFFFF, 0, "R11 restart");
    bucket(0, 0, 16'hFFFF, 0, "R11 restart");
    repeat (4) @(posedge clk);
    #1;
    check("R1 all words delivered", 64'(exp_q.size()), 64'd0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule